// File: doc/BRIEF.md
# Sector Protection and Unprotection Controller

This block holds one protection flag for each sector of a 2 MB flash array and rules on every program or erase request before it reaches the array. A request names a byte address. The block finds the sector that holds that address and grants or refuses the request from that sector's flag. A whole-array erase is answered with a mask of the sectors that may be erased. The flags are changed by operation strobes. Each strobe is qualified by digital stand-ins for the high-voltage levels and by a code carried on three address bits. A verify read reports the flag of the addressed sector.

Protect sets the flag of one sector. Unprotect runs a two-cycle sequence. It first raises every flag, so that no sector is cleared from the unprotected state, and then clears all of them together. Sectors that must stay locked are then protected again one by one. Holding the reset-line qualifier high opens a temporary window. In that window every request is granted, but the stored flags are left untouched. When the qualifier drops, the earlier protection applies again at once.

Top module: `sp_protect_ctrl`

## Requirements
- R1: After reset, all sector flags are 0 and the outputs busy, pe_ack, permit, erase_mask, verify_valid and verify_bit are all 0.
- R2: The sector index is taken from the byte address, counting up from address 0. Sector 0 is 0x0000-0x3FFF, sector 1 is 0x4000-0x5FFF, sector 2 is 0x6000-0x7FFF and sector 3 is 0x8000-0xFFFF. Each 64 KB block k (k = 1..31) at k*0x10000 is sector k+3, giving 35 sectors in all.
- R3: An op_strobe that is qualified and carries addr[6]=0, addr[1]=1, addr[0]=0 sets the flag of the addressed sector only. A verify_req gives verify_valid=1 one cycle later, with verify_bit equal to the addressed sector's flag (1 = protected).
- R4: A strobe is qualified when hv_rst=1, or when hv_a9=1 and hv_oe=1 together. A strobe with no qualifier, with only one of hv_a9 and hv_oe, or with any address code other than the two defined ones leaves every flag unchanged.
- R5: A qualified strobe with addr[6]=1, addr[1]=1, addr[0]=0 raises busy for exactly two cycles. In the first cycle every flag is set. In the second cycle every flag is cleared. Strobes accepted while busy=1 are ignored.
- R6: A pe_req with pe_chip=0 gives pe_ack=1 one cycle later. permit is then the inverse of the addressed sector's flag, and erase_mask is 0.
- R7: A pe_req with pe_chip=1 gives erase_mask bit i = 1 exactly for the sectors whose flag is 0. permit=1 when that mask is non-zero.
- R8: While hv_rst=1, every request is granted and a whole-array request returns a mask of all ones. The stored flags are not changed by this, and the old protection applies again from the first request after hv_rst returns to 0.
- R9: A pe_req accepted while busy=1 is answered with permit=0 and erase_mask=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 21 | Byte address: selects the sector, and bits 6/1/0 carry the operation code |
| op_strobe | input | 1 | Protection operation cycle |
| hv_rst | input | 1 | Reset-line high-voltage qualifier; it also holds the temporary window open |
| hv_a9 | input | 1 | Address-line high-voltage qualifier |
| hv_oe | input | 1 | Output-enable control level that goes with hv_a9 |
| pe_req | input | 1 | Program or erase request |
| pe_chip | input | 1 | 1 = whole-array erase, 0 = single-sector request |
| verify_req | input | 1 | Verify read of the addressed sector |
| busy | output | 1 | Unprotect sequence in progress |
| pe_ack | output | 1 | Request answer valid |
| permit | output | 1 | Request granted |
| erase_mask | output | 35 | Sectors that may be erased |
| verify_valid | output | 1 | verify_bit valid |
| verify_bit | output | 1 | Flag of the addressed sector |

## Verification
The hardest case to reach is the unprotect sequence while other traffic is arriving. The ports can only show it through busy and through requests made in its two cycles. The bench therefore issues a request in the first busy cycle and a protect strobe in the second, and then reads back every sector. Sector boundaries are exercised by protecting at the last bytes of the small sectors and verifying both sides of each edge. The temporary window is exercised by holding hv_rst, reading a protected sector during the window, and requesting the same sector again after release.

// File: rtl/sp_pkg.sv
package sp_pkg;

   typedef enum logic [1:0] {
      OP_NONE   = 2'd0,
      OP_PROT   = 2'd1,
      OP_UNPROT = 2'd2
   } prot_op_e;

   typedef enum logic [1:0] {
      SQ_IDLE    = 2'd0,
      SQ_PRECOND = 2'd1,
      SQ_CLEAR   = 2'd2
   } seq_st_e;

   // four small sectors share the lowest large block, then one sector per large block
   function automatic int sect_count(int addr_w, int main_lg);
      return 3 + (1 << (addr_w - main_lg));
   endfunction

endpackage

// File: rtl/sp_sect_decode.sv
module sp_sect_decode #(
   parameter int ADDR_W  = 21,
   parameter int MAIN_LG = 16,
   parameter int SECT_W  = 6
) (
   input  logic [ADDR_W-1:MAIN_LG-3] addr_hi,
   output logic [SECT_W-1:0]         sect
);
   localparam int TOP_W = ADDR_W - MAIN_LG;

   logic [TOP_W-1:0] blk;
   logic [1:0]       quarter;
   logic             eighth;

   assign blk     = addr_hi[ADDR_W-1:MAIN_LG];
   assign quarter = addr_hi[MAIN_LG-1:MAIN_LG-2];
   assign eighth  = addr_hi[MAIN_LG-3];

   always_comb begin
      if (blk != '0) begin
         sect = SECT_W'(blk) + SECT_W'(3);
      end else begin
         unique case (quarter)
            2'd0:    sect = SECT_W'(0);
            2'd1:    sect = eighth ? SECT_W'(2) : SECT_W'(1);
            default: sect = SECT_W'(3);
         endcase
      end
   end
endmodule

// File: rtl/sp_op_decode.sv
module sp_op_decode
   import sp_pkg::*;
(
   input  logic     op_strobe,
   input  logic     hv_rst,
   input  logic     hv_a9,
   input  logic     hv_oe,
   input  logic     a6,
   input  logic     a1,
   input  logic     a0,
   output prot_op_e op
);
   logic qual;
   logic code_ok;

   assign qual    = hv_rst | (hv_a9 & hv_oe);
   assign code_ok = a1 & ~a0;

   always_comb begin
      op = OP_NONE;
      if (op_strobe && qual && code_ok) begin
         op = a6 ? OP_UNPROT : OP_PROT;
      end
   end
endmodule

// File: rtl/sp_seq.sv
module sp_seq
   import sp_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  prot_op_e op,
   output logic     busy,
   output logic     set_one,
   output logic     set_all,
   output logic     clr_all
);
   seq_st_e st;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= SQ_IDLE;
      end else begin
         unique case (st)
            SQ_IDLE:    if (op == OP_UNPROT) st <= SQ_PRECOND;
            SQ_PRECOND: st <= SQ_CLEAR;
            SQ_CLEAR:   st <= SQ_IDLE;
            default:    st <= SQ_IDLE;
         endcase
      end
   end

   assign busy    = (st != SQ_IDLE);
   assign set_one = (st == SQ_IDLE) && (op == OP_PROT);
   assign set_all = (st == SQ_PRECOND);
   assign clr_all = (st == SQ_CLEAR);
endmodule

// File: rtl/sp_prot_array.sv
module sp_prot_array #(
   parameter int NUM_SECT = 35,
   parameter int SECT_W   = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                set_one,
   input  logic [SECT_W-1:0]   idx,
   input  logic                set_all,
   input  logic                clr_all,
   output logic [NUM_SECT-1:0] bits
);
   for (genvar i = 0; i < NUM_SECT; i++) begin : g_flag
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            bits[i] <= 1'b0;
         end else if (clr_all) begin
            bits[i] <= 1'b0;
         end else if (set_all) begin
            bits[i] <= 1'b1;
         end else if (set_one && (idx == SECT_W'(i))) begin
            bits[i] <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/sp_pe_gate.sv
module sp_pe_gate #(
   parameter int NUM_SECT = 35
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                pe_req,
   input  logic                pe_chip,
   input  logic                busy,
   input  logic                temp,
   input  logic                sect_bit,
   input  logic [NUM_SECT-1:0] bits,
   output logic                pe_ack,
   output logic                permit,
   output logic [NUM_SECT-1:0] erase_mask
);
   logic [NUM_SECT-1:0] free_mask;

   assign free_mask = temp ? {NUM_SECT{1'b1}} : ~bits;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pe_ack     <= 1'b0;
         permit     <= 1'b0;
         erase_mask <= '0;
      end else begin
         pe_ack <= pe_req;
         if (pe_req && !busy && pe_chip) begin
            erase_mask <= free_mask;
            permit     <= |free_mask;
         end else if (pe_req && !busy) begin
            erase_mask <= '0;
            permit     <= temp | ~sect_bit;
         end else begin
            erase_mask <= '0;
            permit     <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/sp_protect_ctrl.sv
module sp_protect_ctrl
   import sp_pkg::*;
#(
   parameter int ADDR_W   = 21,
   parameter int MAIN_LG  = 16,
   parameter int NUM_SECT = sp_pkg::sect_count(ADDR_W, MAIN_LG),
   parameter int SECT_W   = $clog2(NUM_SECT)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   addr,
   input  logic                op_strobe,
   input  logic                hv_rst,
   input  logic                hv_a9,
   input  logic                hv_oe,
   input  logic                pe_req,
   input  logic                pe_chip,
   input  logic                verify_req,
   output logic                busy,
   output logic                pe_ack,
   output logic                permit,
   output logic [NUM_SECT-1:0] erase_mask,
   output logic                verify_valid,
   output logic                verify_bit
);
   if (MAIN_LG < 7 || ADDR_W <= MAIN_LG) begin : g_bad_geom
      $error("sp_protect_ctrl: address geometry too small");
   end
   if (NUM_SECT != sp_pkg::sect_count(ADDR_W, MAIN_LG)) begin : g_bad_count
      $error("sp_protect_ctrl: NUM_SECT does not match geometry");
   end

   logic [SECT_W-1:0]   sect;
   prot_op_e            op;
   logic                set_one, set_all, clr_all;
   logic [NUM_SECT-1:0] prot_bits;
   logic                sect_bit;
   logic                unused_addr;

   assign unused_addr = ^addr;

   sp_sect_decode #(.ADDR_W(ADDR_W), .MAIN_LG(MAIN_LG), .SECT_W(SECT_W)) u_dec (
      .addr_hi (addr[ADDR_W-1:MAIN_LG-3]),
      .sect    (sect)
   );

   sp_op_decode u_opd (
      .op_strobe (op_strobe),
      .hv_rst    (hv_rst),
      .hv_a9     (hv_a9),
      .hv_oe     (hv_oe),
      .a6        (addr[6]),
      .a1        (addr[1]),
      .a0        (addr[0]),
      .op        (op)
   );

   sp_seq u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .op      (op),
      .busy    (busy),
      .set_one (set_one),
      .set_all (set_all),
      .clr_all (clr_all)
   );

   sp_prot_array #(.NUM_SECT(NUM_SECT), .SECT_W(SECT_W)) u_arr (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_one (set_one),
      .idx     (sect),
      .set_all (set_all),
      .clr_all (clr_all),
      .bits    (prot_bits)
   );

   assign sect_bit = prot_bits[sect];

   sp_pe_gate #(.NUM_SECT(NUM_SECT)) u_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .pe_req     (pe_req),
      .pe_chip    (pe_chip),
      .busy       (busy),
      .temp       (hv_rst),
      .sect_bit   (sect_bit),
      .bits       (prot_bits),
      .pe_ack     (pe_ack),
      .permit     (permit),
      .erase_mask (erase_mask)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         verify_valid <= 1'b0;
         verify_bit   <= 1'b0;
      end else begin
         verify_valid <= verify_req;
         verify_bit   <= verify_req & sect_bit;
      end
   end
endmodule

// File: rtl/sp_protect_ctrl_chk.sv
module sp_protect_ctrl_chk #(
   parameter int NUM_SECT = 35
) (
   input logic                clk,
   input logic                rst_n,
   input logic                op_strobe,
   input logic                hv_rst,
   input logic                pe_req,
   input logic                verify_req,
   input logic                busy,
   input logic                clr_all,
   input logic                pe_ack,
   input logic                permit,
   input logic [NUM_SECT-1:0] erase_mask,
   input logic                verify_valid,
   input logic [NUM_SECT-1:0] prot_bits
);
   // R5: the clearing cycle only ever starts from a fully set array
   a_r5_precond_full: assert property (@(posedge clk) disable iff (!rst_n)
      clr_all |-> (&prot_bits));

   // R5: the clearing cycle leaves every flag at zero
   a_r5_all_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      clr_all |=> (prot_bits == '0));

   // R6: every request is answered in the next cycle
   a_r6_ack_follows: assert property (@(posedge clk) disable iff (!rst_n)
      pe_req |=> pe_ack);

   // R3: verify answers one cycle later
   a_r3_verify_follows: assert property (@(posedge clk) disable iff (!rst_n)
      verify_req |=> verify_valid);

   // R8: the temporary window grants requests
   a_r8_temp_grants: assert property (@(posedge clk) disable iff (!rst_n)
      (pe_req && hv_rst && !busy) |=> permit);

   // R8: the window alone does not alter stored flags
   a_r8_flags_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (hv_rst && !op_strobe && !busy) |=> $stable(prot_bits));

   // R9: requests during the unprotect sequence are refused
   a_r9_busy_refuse: assert property (@(posedge clk) disable iff (!rst_n)
      (pe_req && busy) |=> (!permit && erase_mask == '0));
endmodule

bind sp_protect_ctrl sp_protect_ctrl_chk #(.NUM_SECT(NUM_SECT)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .op_strobe    (op_strobe),
   .hv_rst       (hv_rst),
   .pe_req       (pe_req),
   .verify_req   (verify_req),
   .busy         (busy),
   .clr_all      (clr_all),
   .pe_ack       (pe_ack),
   .permit       (permit),
   .erase_mask   (erase_mask),
   .verify_valid (verify_valid),
   .prot_bits    (prot_bits)
);

// File: tb/sp_protect_ctrl_tb.sv
`timescale 1ns/1ps
module sp_protect_ctrl_tb;
   localparam int NS = 35;
   localparam int AW = 21;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          op_strobe = 1'b0, hv_rst = 1'b0, hv_a9 = 1'b0, hv_oe = 1'b0;
   logic          pe_req = 1'b0, pe_chip = 1'b0, verify_req = 1'b0;
   logic          busy, pe_ack, permit, verify_valid, verify_bit;
   logic [NS-1:0] erase_mask;

   always #4 clk = ~clk;

   sp_protect_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .op_strobe(op_strobe),
      .hv_rst(hv_rst), .hv_a9(hv_a9), .hv_oe(hv_oe), .pe_req(pe_req),
      .pe_chip(pe_chip), .verify_req(verify_req), .busy(busy),
      .pe_ack(pe_ack), .permit(permit), .erase_mask(erase_mask),
      .verify_valid(verify_valid), .verify_bit(verify_bit)
   );

   typedef struct {
      bit            is_ver;
      bit            permit;
      logic [NS-1:0] mask;
      bit            vbit;
   } exp_t;

   exp_t  exp_q[$];
   string tag_q[$];
   int    n_run = 0, n_fail = 0;
   bit    done = 1'b0;
   logic [NS-1:0] mdl = '0;

   function automatic int sbase(int s);
      if (s == 0) return 0;
      if (s == 1) return 'h4000;
      if (s == 2) return 'h6000;
      if (s == 3) return 'h8000;
      return (s - 3) << 16;
   endfunction

   function automatic int slast(int s);
      if (s == NS - 1) return (1 << AW) - 1;
      return sbase(s + 1) - 1;
   endfunction

   task automatic chk(string tag, logic [63:0] act, logic [63:0] expv);
      n_run++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && (pe_ack || verify_valid)) begin
         if (exp_q.size() == 0) begin
            n_run++; n_fail++;
            $display("FAIL R6 actual=unexpected response expected=none");
         end else begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (e.is_ver) begin
               chk({t, " verify_valid"}, 64'(verify_valid), 64'd1);
               chk({t, " verify_bit"}, 64'(verify_bit), 64'(e.vbit));
            end else begin
               chk({t, " pe_ack"}, 64'(pe_ack), 64'd1);
               chk({t, " permit"}, 64'(permit), 64'(e.permit));
               chk({t, " mask"}, 64'(erase_mask), 64'(e.mask));
            end
         end
      end
   end

   task automatic op(int a, bit r, bit a9, bit oe);
      @(negedge clk);
      addr = AW'(a); hv_rst = r; hv_a9 = a9; hv_oe = oe; op_strobe = 1'b1;
      @(negedge clk);
      op_strobe = 1'b0; hv_rst = 1'b0; hv_a9 = 1'b0; hv_oe = 1'b0;
   endtask

   task automatic verify(int a, string tag);
      exp_t e;
      @(negedge clk);
      addr = AW'(a); verify_req = 1'b1;
      e.is_ver = 1'b1; e.permit = 1'b0; e.mask = '0;
      e.vbit = mdl[sect_of(a)];
      exp_q.push_back(e); tag_q.push_back(tag);
      @(negedge clk);
      verify_req = 1'b0;
   endtask

   function automatic int sect_of(int a);
      for (int s = 0; s < NS; s++) if (a >= sbase(s) && a <= slast(s)) return s;
      return 0;
   endfunction

   // builds the expected answer from the model and the window state
   function automatic exp_t pe_exp(int a, bit chip, bit temp, bit bsy);
      exp_t e;
      e.is_ver = 1'b0; e.vbit = 1'b0; e.mask = '0; e.permit = 1'b0;
      if (!bsy) begin
         if (chip) begin
            e.mask = temp ? {NS{1'b1}} : ~mdl;
            e.permit = (e.mask != '0);
         end else begin
            e.permit = temp || !mdl[sect_of(a)];
         end
      end
      return e;
   endfunction

   task automatic pe(int a, bit chip, string tag);
      @(negedge clk);
      addr = AW'(a); pe_chip = chip; pe_req = 1'b1;
      exp_q.push_back(pe_exp(a, chip, hv_rst, 1'b0)); tag_q.push_back(tag);
      @(negedge clk);
      pe_req = 1'b0; pe_chip = 1'b0;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      chk("R1 busy", 64'(busy), 0);
      chk("R1 pe_ack", 64'(pe_ack), 0);
      chk("R1 permit", 64'(permit), 0);
      chk("R1 mask", 64'(erase_mask), 0);
      chk("R1 verify_valid", 64'(verify_valid), 0);
      chk("R1 verify_bit", 64'(verify_bit), 0);
      rst_n = 1'b1;
      for (int s = 0; s < NS; s++) verify(sbase(s), "R1 flag clear");

      // R3 protect through the reset-line qualifier, near sector ends (R2)
      op('h3F82, 1, 0, 0);     mdl[0] = 1'b1;
      op('h7F82, 1, 0, 0);     mdl[2] = 1'b1;
      op('h1FFF82, 1, 0, 0);   mdl[34] = 1'b1;
      op('h10002, 0, 1, 1);    mdl[4] = 1'b1;   // R4 address-line path
      for (int s = 0; s < NS; s++) verify(slast(s), "R2 R3 last byte");
      for (int s = 0; s < NS; s++) verify(sbase(s) + 'h80, "R2 R3 low byte");

      // R4 ignored strobes
      op(sbase(5) | 'h1, 1, 0, 0);
      op(sbase(6) | 'h2, 0, 0, 0);
      op(sbase(7) | 'h2, 0, 1, 0);
      op(sbase(8) | 'h2, 0, 0, 1);
      op(sbase(11) | 'h3, 1, 0, 0);
      for (int s = 5; s <= 11; s++) verify(sbase(s), "R4 ignored strobe");
      op(sbase(9) | 'h2, 0, 1, 1); mdl[9] = 1'b1;
      verify(sbase(9), "R4 qualified address-line path");

      // R6 single-sector requests
      pe(sbase(0), 0, "R6 sector0");
      pe(sbase(1), 0, "R6 sector1");
      pe(slast(2), 0, "R6 sector2");
      pe(sbase(3), 0, "R6 sector3");
      pe(slast(34), 0, "R6 sector34");
      pe(sbase(33), 0, "R6 sector33");
      // R7 whole-array erase
      pe(0, 1, "R7 chip mask");

      // R8 temporary window
      @(negedge clk); hv_rst = 1'b1;
      pe(sbase(0), 0, "R8 window grant");
      pe(sbase(9), 0, "R8 window grant");
      pe(0, 1, "R8 window mask");
      verify(sbase(0), "R8 flag kept");
      verify(sbase(9), "R8 flag kept");
      @(negedge clk); hv_rst = 1'b0;
      pe(sbase(0), 0, "R8 protection back");
      pe(0, 1, "R8 mask back");

      // R5 unprotect with traffic in both busy cycles
      @(negedge clk);
      addr = AW'(sbase(10) | 'h42); hv_a9 = 1'b1; hv_oe = 1'b1; op_strobe = 1'b1;
      @(negedge clk);
      op_strobe = 1'b0; hv_a9 = 1'b0; hv_oe = 1'b0;
      chk("R5 busy first", 64'(busy), 1);
      addr = AW'(sbase(1)); pe_req = 1'b1;
      exp_q.push_back(pe_exp(sbase(1), 0, 0, 1)); tag_q.push_back("R9 busy refuse");
      @(negedge clk);
      pe_req = 1'b0;
      chk("R5 busy second", 64'(busy), 1);
      addr = AW'(sbase(12) | 'h2); hv_rst = 1'b1; op_strobe = 1'b1;
      @(negedge clk);
      op_strobe = 1'b0; hv_rst = 1'b0;
      chk("R5 busy done", 64'(busy), 0);
      mdl = '0;
      for (int s = 0; s < NS; s++) verify(sbase(s), "R5 all cleared");

      // R3 individual re-protect after unprotect
      op(sbase(20) | 'h2, 1, 0, 0); mdl[20] = 1'b1;
      verify(sbase(20), "R3 reprotect");
      verify(sbase(21), "R3 neighbour");
      pe(sbase(20), 0, "R6 reprotected deny");
      pe(0, 1, "R7 mask after reprotect");

      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) begin
         n_run++; n_fail++;
         $display("FAIL R6 actual=%0d pending expected=0", exp_q.size());
      end
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule